// File: doc/BRIEF.md
# Gated serial flash clock generator

This block produces the serial clock for a flash interface from the controller's core clock. A two-bit selector picks a power-of-two divider. The serial clock runs only while at least one of two clock enables is set: one for normal use and one for boot use. Each half period of the serial clock lasts 2^sel core cycles, so a full period takes 2·2^sel cycles. Alongside the clock, the block issues a one-cycle data-launch strobe. A phase selector places that strobe either on the falling edge of the serial clock (180-degree mode) or in the middle of the high phase (90-degree mode).

Stopping and restarting happen only at period boundaries. When software clears both enables, the clock finishes its current period and parks low. On the same edge that parks it, a stopped flag rises. The divider and phase settings reach the counter only while the clock is parked. A change made while the clock runs is held back until the next stop. On restart, the first rising edge clears the stopped flag, and the pulse it starts has full width. Software must not reconfigure until a configuration-safe flag is set. That flag combines the stopped status with an idle indication from the transfer sequencer and with busy indications from the bus side.

Top module: `flash_sclk_gen`

## Requirements
- R1: While reset is active and after reset is released, `sclk_o` is 0, `clk_stopped_o` is 1 and `launch_o` is 0 until an enable is set.
- R2: While running with an applied selector value s (0→1, 1→2, 2→4, 3→8), `sclk_o` toggles every 2^s core cycles: it is high for 2^s cycles and then low for 2^s cycles.
- R3: The clock is requested while either enable is set. The enables are sampled one cycle after they change. On the following edge `sclk_o` rises and `clk_stopped_o` falls together. Clearing only one of the two enables does not stop the clock.
- R4: Once both enables are clear, the clock stops only after a complete low phase, which is the moment the next rising edge would occur. `clk_stopped_o` rises on that edge, and `sclk_o` stays 0 for as long as the flag is set.
- R5: The first high phase after a restart lasts the full 2^s cycles.
- R6: A selector value presented while the clock runs has no effect on the period. The value presented on the restart edge is the one applied.
- R7: `cfg_safe_o` is 1 exactly when `clk_stopped_o` is 1, `seq_idle_i` is 1, and both `bus_rd_busy_i` and `bus_wr_busy_i` are 0.
- R8: With phase select 0 (180-degree mode), `launch_o` pulses for one cycle in the same cycle that `sclk_o` turns low.
- R9: With phase select 1 (90-degree mode) and s ≥ 1, `launch_o` pulses 2^(s-1) cycles after `sclk_o` rises, while `sclk_o` is still high. With s = 0 it falls back to the falling edge.
- R10: The phase select follows the same rule as the selector: a change made while the clock runs applies only from the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_run_i | input | 1 | Normal clock enable |
| clk_en_boot_i | input | 1 | Boot clock enable |
| div_sel_i | input | DIV_W | Divider selector, half period = 2^value cycles |
| phase90_i | input | 1 | 1 = 90-degree launch point, 0 = 180-degree |
| seq_idle_i | input | 1 | Transfer sequencer idle indication |
| bus_rd_busy_i | input | 1 | Bus read in progress |
| bus_wr_busy_i | input | 1 | Bus write in progress |
| sclk_o | output | 1 | Serial flash clock, idles low |
| launch_o | output | 1 | One-cycle data-launch strobe |
| clk_stopped_o | output | 1 | Serial clock is parked |
| cfg_safe_o | output | 1 | Configuration may be changed |

## Verification
The assertions check the following on every cycle:
- The clock is low whenever the stopped flag is set.
- The flag falls only together with a rising edge, and only after a sampled request.
- The flag rises only at the end of a low phase, and only when no enable is set.
- The applied settings never move while the clock runs.
- Each launch pulse sits at its phase-dependent point.

Period lengths for each selector value, the full width of the first pulse after restart, the one-enable-only case and the hold-off of settings changed mid-run can only be shown by the bench. It compares a cycle-level model against the outputs across those scenarios.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

  typedef enum logic {
    GATE_PARKED  = 1'b0,
    GATE_RUNNING = 1'b1
  } gate_state_e;

  function automatic int unsigned max_half_log2(input int unsigned sel_w);
    return (1 << sel_w) - 1;
  endfunction

endpackage

// File: rtl/sclk_rst_sync.sv
module sclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ph90_i,
  output logic [DIV_W-1:0] div_o,
  output logic             ph90_o
);

  logic [DIV_W-1:0] div_q, div_d;
  logic             ph90_q, ph90_d;

  always_comb begin
    div_d  = div_q;
    ph90_d = ph90_q;
    if (load_i) begin
      div_d  = div_i;
      ph90_d = ph90_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ph90_q <= 1'b0;
    end else if (load_i) begin
      div_q  <= div_d;
      ph90_q <= ph90_d;
    end
  end

  assign div_o  = div_q;
  assign ph90_o = ph90_q;

  // R6 and R10: applied settings stay frozen while the clock is not parked
  a_r6_hold_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_i) |-> ($stable(div_q) && $stable(ph90_q)));

endmodule

// File: rtl/sclk_gate_ctl.sv
module sclk_gate_ctl
  import sclk_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_run_i,
  input  logic en_boot_i,
  input  logic low_end_i,
  output logic start_o,
  output logic stop_o,
  output logic running_o,
  output logic parked_o
);

  logic        req_q;
  logic        req_d;
  gate_state_e state_q, state_d;

  always_comb begin
    req_d   = en_run_i | en_boot_i;
    state_d = state_q;
    start_o = 1'b0;
    stop_o  = 1'b0;
    unique case (state_q)
      GATE_PARKED: begin
        if (req_q) begin
          start_o = 1'b1;
          state_d = GATE_RUNNING;
        end
      end
      GATE_RUNNING: begin
        if (!req_q && low_end_i) begin
          stop_o  = 1'b1;
          state_d = GATE_PARKED;
        end
      end
      default: state_d = GATE_PARKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      state_q <= GATE_PARKED;
    end else begin
      req_q   <= req_d;
      state_q <= state_d;
    end
  end

  assign running_o = (state_q == GATE_RUNNING);
  assign parked_o  = (state_q == GATE_PARKED);

  // R3: leaving the parked state needs a sampled request
  a_r3_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(parked_o) |-> $past(req_q));

  // R4: parking only at the end of a low phase with no request
  a_r4_park_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(parked_o) |-> ($past(low_end_i) && !$past(req_q)));

endmodule

// File: rtl/sclk_div_core.sv
module sclk_div_core
  import sclk_gen_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ph90_i,
  output logic             sclk_o,
  output logic             launch_o,
  output logic             low_end_o
);

  localparam int unsigned HALF_LOG2 = max_half_log2(DIV_W);
  localparam int CNT_W = (HALF_LOG2 > 0) ? HALF_LOG2 : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             launch_q, launch_d;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] mid;
  logic             at_lim;
  logic             quarter_mode;
  logic             launch_pt;
  logic             cnt_en;

  always_comb begin
    lim          = CNT_W'((32'd1 << div_i) - 32'd1);
    mid          = lim >> 1;
    at_lim       = (cnt_q == lim);
    quarter_mode = ph90_i && (div_i != '0);
    launch_pt    = quarter_mode ? (cnt_q == mid) : at_lim;
    cnt_en       = start_i | stop_i | running_i;
  end

  always_comb begin
    cnt_d    = cnt_q;
    sclk_d   = sclk_q;
    launch_d = 1'b0;
    if (start_i) begin
      cnt_d  = '0;
      sclk_d = 1'b1;
    end else if (stop_i) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (running_i) begin
      launch_d = sclk_q && launch_pt;
      if (at_lim) begin
        cnt_d  = '0;
        sclk_d = ~sclk_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      launch_q <= 1'b0;
    end else begin
      launch_q <= launch_d;
    end
  end

  assign sclk_o    = sclk_q;
  assign launch_o  = launch_q;
  assign low_end_o = running_i && !sclk_q && at_lim;

  // R8: in half-period mode the launch pulse coincides with the falling edge
  a_r8_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_q && !quarter_mode) |-> $fell(sclk_q));

  // R9: in quarter mode the launch pulse lands while the clock is high
  a_r9_launch_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_q && quarter_mode) |-> (sclk_q && $stable(sclk_q)));

endmodule

// File: rtl/flash_sclk_gen.sv
module flash_sclk_gen #(
  parameter int DIV_W      = 2,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_run_i,
  input  logic             clk_en_boot_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             phase90_i,
  input  logic             seq_idle_i,
  input  logic             bus_rd_busy_i,
  input  logic             bus_wr_busy_i,
  output logic             sclk_o,
  output logic             launch_o,
  output logic             clk_stopped_o,
  output logic             cfg_safe_o
);

  logic             rst_n_int;
  logic             start, stop, running, parked, low_end;
  logic [DIV_W-1:0] div_act;
  logic             ph90_act;

  sclk_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_int)
  );

  sclk_gate_ctl u_gate (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .en_run_i  (clk_en_run_i),
    .en_boot_i (clk_en_boot_i),
    .low_end_i (low_end),
    .start_o   (start),
    .stop_o    (stop),
    .running_o (running),
    .parked_o  (parked)
  );

  sclk_cfg_hold #(.DIV_W(DIV_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load_i (parked),
    .div_i  (div_sel_i),
    .ph90_i (phase90_i),
    .div_o  (div_act),
    .ph90_o (ph90_act)
  );

  sclk_div_core #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .running_i (running),
    .start_i   (start),
    .stop_i    (stop),
    .div_i     (div_act),
    .ph90_i    (ph90_act),
    .sclk_o    (sclk_o),
    .launch_o  (launch_o),
    .low_end_o (low_end)
  );

  assign clk_stopped_o = parked;
  assign cfg_safe_o    = parked && seq_idle_i && !bus_rd_busy_i && !bus_wr_busy_i;

  // R4: a parked clock holds its idle low level
  a_r4_parked_low: assert property (@(posedge clk) disable iff (!rst_n_int)
    clk_stopped_o |-> !sclk_o);

  // R3: the stopped flag clears on the same edge as the first rising edge
  a_r3_unpark_with_rise: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(clk_stopped_o) |-> $rose(sclk_o));

endmodule

// File: tb/test_flash_sclk_gen.sv
module test_flash_sclk_gen;
  localparam int DW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, en_run, en_boot, ph90, idle, rd_busy, wr_busy;
  logic [DW-1:0] div;
  logic          sclk, launch, stopped, safe;

  flash_sclk_gen #(.DIV_W(DW)) i_flash_sclk_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .clk_en_run_i  (en_run),
    .clk_en_boot_i (en_boot),
    .div_sel_i     (div),
    .phase90_i     (ph90),
    .seq_idle_i    (idle),
    .bus_rd_busy_i (rd_busy),
    .bus_wr_busy_i (wr_busy),
    .sclk_o        (sclk),
    .launch_o      (launch),
    .clk_stopped_o (stopped),
    .cfg_safe_o    (safe)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural model: position inside the serial period, counted from the rise
  int rel_m, pos_m, n_m;
  bit run_m, req_m, ph_m, launch_m;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || rel_m < 2) begin
      if (!rst_n) rel_m = 0; else rel_m++;
      run_m = 0; pos_m = 0; n_m = 1; ph_m = 0; req_m = 0; launch_m = 0;
    end else begin
      launch_m = 0;
      if (!run_m) begin
        n_m  = 1 << div;
        ph_m = ph90;
        if (req_m) begin
          run_m = 1;
          pos_m = 0;
        end
      end else if (pos_m == 2 * n_m - 1) begin
        pos_m = 0;
        if (!req_m) run_m = 0;
      end else begin
        pos_m++;
        launch_m = (pos_m == ((ph_m && n_m >= 2) ? n_m / 2 : n_m));
      end
      req_m = en_run | en_boot;
    end
  end

  always @(negedge clk) begin
    chk("R2 sclk per-cycle", sclk, (run_m && pos_m < n_m));
    chk("R4 stopped per-cycle", stopped, !run_m);
    chk("R8 launch per-cycle", launch, launch_m);
    chk("R7 cfg_safe per-cycle", safe, (!run_m && idle && !rd_busy && !wr_busy));
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic high_len(input bit skip_cur, output int len);
    len = 0;
    if (skip_cur) begin
      while (sclk === 1'b1) step(1);
    end
    while (sclk !== 1'b1) step(1);
    while (sclk === 1'b1) begin
      len++;
      step(1);
    end
  endtask

  task automatic rise_to_launch(output int d);
    d = 0;
    while (sclk === 1'b1) step(1);
    while (sclk !== 1'b1) step(1);
    while (launch !== 1'b1 && d < 40) begin
      d++;
      step(1);
    end
  endtask

  task automatic park();
    en_run = 0; en_boot = 0;
    while (stopped !== 1'b1) step(1);
  endtask

  initial begin
    int len;
    rel_m = 0;
    rst_n = 0; en_run = 0; en_boot = 0; ph90 = 0; idle = 1; rd_busy = 0; wr_busy = 0;
    div = 2'd0;
    step(3);
    chk("R1 reset sclk", sclk, 0);
    chk("R1 reset stopped", stopped, 1);
    rst_n = 1;
    step(5);
    chk("R1 post-reset stopped", stopped, 1);
    chk("R1 post-reset launch", launch, 0);

    // R7 flag combinations while parked
    chk("R7 safe all clear", safe, 1);
    rd_busy = 1; step(1); chk("R7 safe read busy", safe, 0);
    rd_busy = 0; wr_busy = 1; step(1); chk("R7 safe write busy", safe, 0);
    wr_busy = 0; idle = 0; step(1); chk("R7 safe sequencer busy", safe, 0);
    idle = 1;

    // R3 start latency, div 0
    en_run = 1;
    step(1);
    chk("R3 still stopped after sampling", stopped, 1);
    step(1);
    chk("R3 stopped cleared", stopped, 0);
    chk("R3 first rise", sclk, 1);
    chk("R7 safe while running", safe, 0);
    high_len(1'b1, len); chk("R2 half period div0", len, 1);

    // R6: selector change while running is ignored
    div = 2'd3;
    step(4);
    high_len(1'b1, len); chk("R6 divider held while running", len, 1);

    // R3: one enable alone keeps the clock alive
    en_boot = 1; step(2); en_run = 0;
    step(20);
    chk("R3 one enable keeps running", stopped, 0);

    // R4 park and hold low
    park();
    step(1);
    chk("R4 parked low", sclk, 0);
    step(15);
    chk("R4 stays low", sclk, 0);
    chk("R4 stays stopped", stopped, 1);

    // R5 restart via boot enable with div 3 applied
    en_boot = 1;
    high_len(1'b0, len); chk("R5 full first pulse div3", len, 8);
    high_len(1'b1, len); chk("R2 half period div3", len, 8);
    rise_to_launch(len); chk("R8 launch at fall div3", len, 8);

    // R10: phase change while running held
    ph90 = 1;
    step(3);
    rise_to_launch(len); chk("R10 phase held while running", len, 8);
    park();

    // R9 quarter launch, div 2
    div = 2'd2; en_run = 1;
    high_len(1'b0, len); chk("R5 full first pulse div2", len, 4);
    rise_to_launch(len); chk("R9 quarter launch div2", len, 2);
    park();

    // R9 fallback at div 0, and div 1 period
    div = 2'd0; en_run = 1;
    step(4);
    rise_to_launch(len); chk("R9 fallback div0", len, 1);
    park();
    div = 2'd1; ph90 = 0; en_boot = 1;
    high_len(1'b0, len); chk("R2 half period div1", len, 2);
    rise_to_launch(len); chk("R8 launch at fall div1", len, 2);
    park();
    step(5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule